// File: doc/BRIEF.md
# Accumulator ALU with Flag Register

This block is the arithmetic and logic stage of a small accumulator machine. Each operation takes the working register value `w_in` as its first operand. For two-operand operations it also takes the scratch operand `temp_in`. It registers the result as the new working value on `w_out`. Alongside the result it keeps a three-bit status register: carry, zero and negative. Each flag is either recomputed or held, depending on the operation.

On a clock edge where `op_valid` is high, the block performs the operation selected by the four-bit code on `op`. On other edges the result and the flags stay as they are. Instruction decoding supplies the code, the bit index and the operands. The surrounding machine feeds `w_out` back as the next `w_in`. The carry flag is supplied to `carry_in` for rotates and add-with-carry.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, `w_out`, `flag_c`, `flag_z` and `flag_n` are all 0 after the next clock edge.
- R2: On an edge where `op_valid` is low, `w_out` and all three flags keep their values.
- R3: For every operation except set-bit (5) and clear-bit (6), `flag_z` becomes 1 exactly when the new `w_out` is zero, and `flag_n` becomes bit 7 of the new `w_out`.
- R4: Code 0 clears W and code 1 inverts W; both keep `flag_c`. Code 4 gives the two's complement of W and sets `flag_c` to 1 when W was nonzero.
- R5: Code 2 adds one to W and sets `flag_c` when W was 0xFF. Code 3 subtracts one from W and sets `flag_c` (borrow) when W was 0x00.
- R6: Code 5 sets bit `bit_sel` of W and code 6 clears it; other bits are unchanged and all three flags hold.
- R7: Code 7 rotates W left through carry: `carry_in` enters bit 0 and old bit 7 goes to `flag_c`. Code 8 rotates right through carry: `carry_in` enters bit 7 and old bit 0 goes to `flag_c`.
- R8: Code 9 shifts W left and code 10 shifts W right, both filling with 0. The bit shifted out goes to `flag_c`.
- R9: Code 11 writes W+TEMP and code 15 writes W+TEMP+`carry_in`, each modulo 256, with `flag_c` taking the carry out of bit 7.
- R10: Codes 12, 13 and 14 write W AND TEMP, W OR TEMP and W XOR TEMP, and keep `flag_c`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Perform `op` on this edge |
| op | input | 4 | Operation code |
| bit_sel | input | 3 | Bit index for set/clear bit |
| w_in | input | 8 | Working register operand |
| temp_in | input | 8 | Scratch operand |
| carry_in | input | 1 | Carry supplied to rotates and add-with-carry |
| w_out | output | 8 | Registered result |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |

## Verification
The bench aims at the wrap points:
- increment of 0xFF and decrement of 0x00, where a wrong carry polarity would report no carry or a spurious borrow;
- negation of zero, whose carry is the odd case;
- add-with-carry at 0xFF+0x00+1, which a design that drops `carry_in` would leave at 0xFF with no carry.

It also runs rotates with both values of `carry_in` and bit operations at indices 0 and 7. A design that let set-bit or clear-bit refresh the zero or negative flags would be caught when the bit operation follows a result whose flags disagree with the new value. Logic operations follow carry-producing ones, so an AND that cleared carry would show up.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     op_valid,
  input  logic [3:0]               op,
  input  logic [$clog2(WIDTH)-1:0] bit_sel,
  input  logic [WIDTH-1:0]         w_in,
  input  logic [WIDTH-1:0]         temp_in,
  input  logic                     carry_in,
  output logic [WIDTH-1:0]         w_out,
  output logic                     flag_c,
  output logic                     flag_z,
  output logic                     flag_n
);
  localparam int MSB = WIDTH - 1;

  localparam logic [3:0] OP_CLR  = 4'd0;
  localparam logic [3:0] OP_NOT  = 4'd1;
  localparam logic [3:0] OP_INC  = 4'd2;
  localparam logic [3:0] OP_DEC  = 4'd3;
  localparam logic [3:0] OP_NEG  = 4'd4;
  localparam logic [3:0] OP_SETB = 4'd5;
  localparam logic [3:0] OP_CLRB = 4'd6;
  localparam logic [3:0] OP_ROL  = 4'd7;
  localparam logic [3:0] OP_ROR  = 4'd8;
  localparam logic [3:0] OP_SHL  = 4'd9;
  localparam logic [3:0] OP_SHR  = 4'd10;
  localparam logic [3:0] OP_ADD  = 4'd11;
  localparam logic [3:0] OP_AND  = 4'd12;
  localparam logic [3:0] OP_OR   = 4'd13;
  localparam logic [3:0] OP_XOR  = 4'd14;
  localparam logic [3:0] OP_ADC  = 4'd15;

  logic [WIDTH-1:0] mask, res;
  logic [WIDTH:0]   sum;
  logic             c_nx, bit_op;

  assign mask   = {{(WIDTH-1){1'b0}}, 1'b1} << bit_sel;
  assign bit_op = (op == OP_SETB) || (op == OP_CLRB);
  assign sum    = {1'b0, w_in} + {1'b0, temp_in} + {{WIDTH{1'b0}}, (op == OP_ADC) & carry_in};

  always_comb begin
    res  = w_in;
    c_nx = flag_c;
    unique case (op)
      OP_CLR:  res = '0;
      OP_NOT:  res = ~w_in;
      OP_INC:  begin res = w_in + 1'b1; c_nx = &w_in; end
      OP_DEC:  begin res = w_in - 1'b1; c_nx = ~|w_in; end
      OP_NEG:  begin res = ~w_in + 1'b1; c_nx = |w_in; end
      OP_SETB: res = w_in | mask;
      OP_CLRB: res = w_in & ~mask;
      OP_ROL:  {c_nx, res} = {w_in, carry_in};
      OP_ROR:  {res, c_nx} = {carry_in, w_in};
      OP_SHL:  {c_nx, res} = {w_in, 1'b0};
      OP_SHR:  {res, c_nx} = {1'b0, w_in};
      OP_ADD, OP_ADC: {c_nx, res} = sum;
      OP_AND:  res = w_in & temp_in;
      OP_OR:   res = w_in | temp_in;
      OP_XOR:  res = w_in ^ temp_in;
      default: res = w_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_out  <= '0;
      flag_c <= 1'b0;
      flag_z <= 1'b0;
      flag_n <= 1'b0;
    end else if (op_valid) begin
      w_out <= res;
      if (!bit_op) begin
        flag_c <= c_nx;
        flag_z <= ~|res;
        flag_n <= res[MSB];
      end
    end
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int WIDTH = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     op_valid,
  input logic [3:0]               op,
  input logic [$clog2(WIDTH)-1:0] bit_sel,
  input logic [WIDTH-1:0]         w_in,
  input logic [WIDTH-1:0]         w_out,
  input logic                     flag_c,
  input logic                     flag_z,
  input logic                     flag_n
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(w_out) && $stable(flag_c) && $stable(flag_z) && $stable(flag_n));

  p_zero_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op != 4'd5 && op != 4'd6 |=> flag_z == (w_out == '0));

  p_neg_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op != 4'd5 && op != 4'd6 |=> flag_n == w_out[WIDTH-1]);

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op == 4'd0 |=> w_out == '0 && flag_z && flag_c == $past(flag_c));

  p_bitop_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op == 4'd5 || op == 4'd6)
    |=> flag_c == $past(flag_c) && flag_z == $past(flag_z) && flag_n == $past(flag_n));

  p_setbit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op == 4'd5 |=> w_out[$past(bit_sel)] == 1'b1);

  p_logic_carry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op == 4'd12 || op == 4'd13 || op == 4'd14) |=> flag_c == $past(flag_c));

  p_inc_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op == 4'd2 && w_in == '1 |=> flag_c && w_out == '0);
endmodule

bind acc_alu acc_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .bit_sel(bit_sel),
  .w_in(w_in), .w_out(w_out), .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n)
);

// File: tb/acc_alu_test.sv
module acc_alu_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op = '0;
  logic [2:0] bit_sel = '0;
  logic [7:0] w_in = '0, temp_in = '0;
  logic       carry_in = 1'b0;
  logic [7:0] w_out;
  logic       flag_c, flag_z, flag_n;

  int compared = 0, mismatched = 0;
  int ew = 0, ec = 0, ez = 0, en = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  acc_alu uut (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .bit_sel(bit_sel),
               .w_in(w_in), .temp_in(temp_in), .carry_in(carry_in),
               .w_out(w_out), .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n));

  function automatic string req_of(int code);
    case (code)
      0, 1, 4:     return "R4";
      2, 3:        return "R5";
      5, 6:        return "R6";
      7, 8:        return "R7";
      9, 10:       return "R8";
      11, 15:      return "R9";
      default:     return "R10";
    endcase
  endfunction

  task automatic check_one(string r, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic compare();
    check_one(tag, "w_out", w_out, ew);
    check_one(tag, "carry", flag_c, ec);
    check_one((tag == "R6" || tag == "R2" || tag == "R1") ? tag : "R3", "zero", flag_z, ez);
    check_one((tag == "R6" || tag == "R2" || tag == "R1") ? tag : "R3", "neg", flag_n, en);
  endtask

  task automatic step(bit v, int code, int idx, int w, int t, bit ci);
    int r, s;
    @(negedge clk);
    compare();
    op_valid = v; op = code[3:0]; bit_sel = idx[2:0];
    w_in = w[7:0]; temp_in = t[7:0]; carry_in = ci;
    if (!v) begin tag = "R2"; return; end
    tag = req_of(code);
    r = w;
    case (code)
      0: r = 0;
      1: r = ~w & 255;
      2: begin r = (w + 1) & 255; ec = (w == 255); end
      3: begin r = (w + 255) & 255; ec = (w == 0); end
      4: begin r = (256 - w) & 255; ec = (w != 0); end
      5: r = w | (1 << idx);
      6: r = w & ~(1 << idx) & 255;
      7: begin r = ((w << 1) | ci) & 255; ec = w >> 7; end
      8: begin r = (w >> 1) | (ci << 7); ec = w & 1; end
      9: begin r = (w << 1) & 255; ec = w >> 7; end
      10: begin r = w >> 1; ec = w & 1; end
      11: begin s = w + t; r = s & 255; ec = s >> 8; end
      12: r = w & t;
      13: r = w | t;
      14: r = w ^ t;
      15: begin s = w + t + ci; r = s & 255; ec = s >> 8; end
      default: r = w;
    endcase
    ew = r;
    if (code != 5 && code != 6) begin ez = (r == 0); en = r >> 7; end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    tag = "R1";
    compare();
    rst_n = 1'b1;
    step(1, 2, 0, 8'hFF, 0, 0);
    step(1, 3, 0, 8'h00, 0, 0);
    step(1, 4, 0, 8'h00, 0, 0);
    step(1, 4, 0, 8'h01, 0, 0);
    step(1, 12, 0, 8'hF0, 8'h0F, 0);
    step(1, 5, 7, 8'h00, 0, 0);
    step(1, 6, 0, 8'h01, 0, 0);
    step(1, 0, 0, 8'h55, 0, 0);
    step(1, 1, 0, 8'h55, 0, 0);
    step(1, 7, 0, 8'h80, 0, 1);
    step(1, 8, 0, 8'h01, 0, 1);
    step(1, 9, 0, 8'h81, 0, 0);
    step(1, 10, 0, 8'h01, 0, 0);
    step(1, 11, 0, 8'h80, 8'h80, 0);
    step(1, 15, 0, 8'hFF, 8'h00, 1);
    step(1, 13, 0, 8'h00, 8'h00, 1);
    step(1, 14, 0, 8'hAA, 8'hFF, 0);
    step(0, 2, 0, 8'h12, 0, 0);
    step(0, 0, 0, 8'h34, 0, 1);
    for (int i = 0; i < 800; i++)
      step($urandom_range(0, 7) != 0, $urandom_range(0, 15), $urandom_range(0, 7),
           (i % 4 == 0) ? w_out : $urandom_range(0, 255), $urandom_range(0, 255),
           $urandom_range(0, 1));
    @(negedge clk);
    compare();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule